// File: doc/BRIEF.md
# Direct-Mapped Translation Lookaside Buffer

This block keeps recently used page table entries close to a segmented address translator. It takes a 7-bit virtual page number made of a 3-bit segment number and a 4-bit page-within-segment field. It reports in the same cycle whether that page's translation is held. On a hit it also returns the physical frame number and the three protection bits. The buffer has sixteen slots, and the slot is picked by the page-within-segment field alone. As a result, the whole page table of one segment fits at once, while pages in different segments that share a page index evict each other.

After a page walk, the translator writes the fetched 16-bit entry through the fill port. A flush input drops every cached translation, for example when a new address space is loaded. Each slot keeps its own presence flag, apart from the valid bit inside the cached entry. Entries whose valid bit is clear are never cached.

Top module: `tlb_dm`

## Requirements
- R1: After reset, every lookup misses until a fill has been accepted.
- R2: A lookup hits, in the same cycle as the request and with no clock edge in between, only when the selected slot is present and its stored tag equals `lk_vpn[6:4]`.
- R3: On a hit, `lk_frame` equals bits [6:0] of the cached entry and `lk_perm` equals bits [10:8] of it.
- R4: A fill with `fill_pte[7]` set writes the slot on the next rising clock edge, and a lookup of the same page number hits from the following cycle on.
- R5: The slot index is `vpn[3:0]` and the tag is `vpn[6:4]`. A fill replaces whatever the slot held, so a page in another segment with the same index then misses.
- R6: Sixteen pages of one segment with distinct indices are all held at the same time.
- R7: When a fill and a lookup address the same slot in one cycle, the lookup reports the contents from before the fill.
- R8: A fill whose entry has bit 7 (valid) clear leaves the slot unchanged.
- R9: A flush makes every slot absent at the next edge, and it overrides a fill in the same cycle.
- R10: On a miss, `lk_frame` and `lk_perm` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all slots at the next edge |
| lk_vpn | input | 7 | Lookup page number: segment [6:4], page index [3:0] |
| lk_hit | output | 1 | Lookup found a matching present slot |
| lk_frame | output | 7 | Frame number of the hit entry |
| lk_perm | output | 3 | Protection bits of the hit entry |
| fill_en | input | 1 | Write request after a page walk |
| fill_vpn | input | 7 | Page number being filled |
| fill_pte | input | 16 | Page table entry: age [15:12], dirty [11], protection [10:8], valid [7], frame [6:0] |

## Verification
The hardest case to reach from the ports is a fill and a lookup meeting on the same slot in the same cycle. The bench first loads a known frame into that slot. It then holds a fill of a different frame pending before the clock edge, samples the lookup outputs while the fill is still pending, and samples them again after the edge to see the new contents. Slot collisions are produced by filling two segments at one page index. Full occupancy is shown by filling every index of a single segment and reading all sixteen back.

// File: rtl/tlb_dm.sv
module tlb_dm #(
  parameter int VPN_W     = 7,
  parameter int IDX_W     = 4,
  parameter int PTE_W     = 16,
  parameter int FRAME_W   = 7,
  parameter int VALID_BIT = 7,
  parameter int PERM_LSB  = 8,
  parameter int PERM_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic [PERM_W-1:0]  lk_perm,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PTE_W-1:0]   fill_pte
);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0] present;
  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [PTE_W-1:0] pte_q [SLOTS];

  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic             fill_ok;

  assign lk_idx   = lk_vpn[IDX_W-1:0];
  assign lk_tag   = lk_vpn[VPN_W-1:IDX_W];
  assign fill_idx = fill_vpn[IDX_W-1:0];
  assign fill_tag = fill_vpn[VPN_W-1:IDX_W];
  assign fill_ok  = fill_en && fill_pte[VALID_BIT] && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      present <= '0;
    else if (flush)
      present <= '0;
    else if (fill_ok)
      present[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      tag_q[fill_idx] <= fill_tag;
      pte_q[fill_idx] <= fill_pte;
    end
  end

  assign lk_hit   = present[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_frame = lk_hit ? pte_q[lk_idx][FRAME_W-1:0] : '0;
  assign lk_perm  = lk_hit ? pte_q[lk_idx][PERM_LSB +: PERM_W] : '0;
endmodule

// File: rtl/tlb_dm_checker.sv
module tlb_dm_checker #(
  parameter int VPN_W     = 7,
  parameter int IDX_W     = 4,
  parameter int PTE_W     = 16,
  parameter int FRAME_W   = 7,
  parameter int VALID_BIT = 7,
  parameter int PERM_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic [VPN_W-1:0]   lk_vpn,
  input logic               lk_hit,
  input logic [FRAME_W-1:0] lk_frame,
  input logic [PERM_W-1:0]  lk_perm,
  input logic               fill_en,
  input logic [VPN_W-1:0]   fill_vpn,
  input logic [PTE_W-1:0]   fill_pte
);
  logic any_fill;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_fill <= 1'b0;
    else if (fill_en && fill_pte[VALID_BIT] && !flush) any_fill <= 1'b1;
  end

  p_cold_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !any_fill |-> !lk_hit);

  p_fill_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_pte[VALID_BIT] && !flush) |=>
      (lk_vpn != $past(fill_vpn)) || (lk_hit && lk_frame == $past(fill_pte[FRAME_W-1:0])));

  p_evict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_pte[VALID_BIT] && !flush &&
     fill_vpn[IDX_W-1:0] == lk_vpn[IDX_W-1:0] &&
     fill_vpn[VPN_W-1:IDX_W] != lk_vpn[VPN_W-1:IDX_W]) |=>
      (lk_vpn != $past(lk_vpn)) || !lk_hit);

  p_invalid_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_pte[VALID_BIT] && !flush && fill_vpn == lk_vpn) |=>
      (lk_vpn != $past(lk_vpn)) || (lk_hit == $past(lk_hit) && lk_frame == $past(lk_frame)));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_frame == '0 && lk_perm == '0));
endmodule

bind tlb_dm tlb_dm_checker #(
  .VPN_W(VPN_W), .IDX_W(IDX_W), .PTE_W(PTE_W), .FRAME_W(FRAME_W),
  .VALID_BIT(VALID_BIT), .PERM_W(PERM_W)
) u_tlb_dm_checker (.*);

// File: tb/tlb_dm_bench.sv
module tlb_dm_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic [6:0] lk_vpn = '0;
  logic       lk_hit;
  logic [6:0] lk_frame;
  logic [2:0] lk_perm;
  logic       fill_en = 1'b0;
  logic [6:0] fill_vpn = '0;
  logic [15:0] fill_pte = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tlb_dm u_tlb_dm (.*);

  function automatic logic [15:0] mk_pte(input logic [6:0] fr, input logic [2:0] pm,
                                          input logic vld, input logic [3:0] age);
    return {age, 1'b1, pm, vld, fr};
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic look(input logic [6:0] v);
    lk_vpn = v;
    #1;
  endtask

  task automatic expect_hit(input string req, input logic [6:0] v,
                            input logic [6:0] fr, input logic [2:0] pm);
    look(v);
    chk(req, lk_hit, 1);
    chk(req, lk_frame, fr);
    chk(req, lk_perm, pm);
  endtask

  task automatic expect_miss(input string req, input logic [6:0] v);
    look(v);
    chk(req, lk_hit, 0);
    chk({req, " R10"}, {lk_perm, lk_frame}, 0);
  endtask

  task automatic do_fill(input logic [6:0] v, input logic [15:0] p);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_pte = p;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    for (int v = 0; v < 128; v++) expect_miss("R1 reset", 7'(v));
  endtask

  task automatic t_basic();
    do_fill(7'h23, mk_pte(7'h4A, 3'b101, 1'b1, 4'h5));
    expect_hit("R3 R4 basic", 7'h23, 7'h4A, 3'b101);
    expect_miss("R2 other segment", 7'h33);
    expect_miss("R2 other index", 7'h24);
  endtask

  task automatic t_full_segment();
    do_flush();
    for (int i = 0; i < 16; i++)
      do_fill({3'd5, 4'(i)}, mk_pte(7'(8'h30 + i), 3'(i), 1'b1, 4'(i)));
    for (int i = 0; i < 16; i++)
      expect_hit("R6 whole segment", {3'd5, 4'(i)}, 7'(8'h30 + i), 3'(i));
    expect_miss("R2 segment 4 absent", {3'd4, 4'd9});
  endtask

  task automatic t_conflict();
    do_fill({3'd2, 4'd3}, mk_pte(7'h0C, 3'b011, 1'b1, 4'h0));
    expect_hit("R5 first owner", {3'd2, 4'd3}, 7'h0C, 3'b011);
    do_fill({3'd6, 4'd3}, mk_pte(7'h61, 3'b110, 1'b1, 4'h0));
    expect_miss("R5 evicted", {3'd2, 4'd3});
    expect_hit("R5 new owner", {3'd6, 4'd3}, 7'h61, 3'b110);
    expect_hit("R5 neighbour kept", {3'd5, 4'd4}, 7'h34, 3'd4);
  endtask

  task automatic t_same_cycle();
    do_fill({3'd1, 4'd7}, mk_pte(7'h11, 3'b001, 1'b1, 4'h0));
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = {3'd1, 4'd7};
    fill_pte = mk_pte(7'h22, 3'b010, 1'b1, 4'h0);
    expect_hit("R7 old contents", {3'd1, 4'd7}, 7'h11, 3'b001);
    @(negedge clk);
    fill_en = 1'b0;
    expect_hit("R7 new after edge", {3'd1, 4'd7}, 7'h22, 3'b010);
  endtask

  task automatic t_invalid();
    do_fill({3'd1, 4'd7}, mk_pte(7'h7F, 3'b111, 1'b0, 4'hF));
    expect_hit("R8 slot unchanged", {3'd1, 4'd7}, 7'h22, 3'b010);
    do_fill({3'd0, 4'd15}, mk_pte(7'h05, 3'b100, 1'b0, 4'h0));
    expect_miss("R8 empty stays empty", {3'd0, 4'd15});
    expect_hit("R8 owner of index 15", {3'd5, 4'd15}, 7'h3F, 3'd7);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 7'h40;
    fill_pte = mk_pte(7'h01, 3'b001, 1'b1, 4'h0);
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    expect_miss("R9 fill overridden", 7'h40);
    expect_miss("R9 cleared", {3'd1, 4'd7});
    expect_miss("R9 cleared", {3'd6, 4'd3});
    for (int i = 0; i < 16; i++) expect_miss("R9 segment gone", {3'd5, 4'(i)});
    do_fill(7'h40, mk_pte(7'h02, 3'b010, 1'b1, 4'h0));
    expect_hit("R9 usable after flush", 7'h40, 7'h02, 3'b010);
  endtask

  initial begin
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_full_segment();
    t_conflict();
    t_same_cycle();
    t_invalid();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule